// File: doc/BRIEF.md
# Two-Priority ADC Scan Sequencer

This block decides which analog channel a shared converter samples next. It keeps two scan sequences, each with its own channel mask and trigger. A normal sequence (A) walks its selected channels in ascending order, either once per trigger or continuously. A priority sequence (B) can cut into a running A scan at any point. The block pulses a start strobe with a channel index to the converter, waits for the converter's done pulse and moves on to the next channel.

When B breaks in, the channel A was converting is thrown away. After B's last channel, A picks up again. A configuration bit decides whether A redoes the channel it lost and carries on from there, or goes back to its first channel. Each sequence sets its own sticky end-of-scan flag, which software clears. The flag drives an interrupt line through a per-sequence enable. A stop input drops every scan at once and sets no flag.

Top module: `adc_scan_seq`

## Requirements
- R1: Within a scan, channels are converted in ascending index order and only channels whose mask bit is 1 are converted.
- R2: A sequence's trigger is selected by its 2-bit code: 0 = its dedicated start input, 1 = external line 0, 2 = external line 1, 3 = either external line. The trigger has effect only while that sequence's trigger enable is 1.
- R3: scan_mode bit 0 set makes A restart from its first channel after each completed scan, until stopped. Clear means one scan per trigger. B triggers are honoured only when scan_mode bit 1 is set (codes 2 and 3), and B always scans once.
- R4: A B trigger during an A scan starts B on the next clock edge. The A conversion in flight is discarded, and a done pulse arriving in that cycle is not credited to A.
- R5: When B finishes, A continues. With resume_sel = 0 it reconverts the interrupted channel and goes on from there. With resume_sel = 1 it starts again from its first channel.
- R6: eoc_a / eoc_b go to 1 in the cycle after the done pulse of the last channel of an A / B scan. They stay 1 until eoc_clr_a / eoc_clr_b is pulsed, and they are 0 after reset.
- R7: irq_a is 1 exactly when eoc_a and ie_a are both 1. irq_b follows the same rule with eoc_b and ie_b.
- R8: A stop pulse ends all scans on the next edge. busy falls, no further conv_start is issued and no end-of-scan flag is set.
- R9: A trigger for A while any scan is active is ignored. A B trigger while B is active is ignored. A trigger for a sequence whose mask is all zero is ignored.
- R10: conv_start is a one-cycle pulse that is only issued while busy. conv_ch holds the channel to convert during that pulse. A new conv_start abandons any conversion still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_mode | input | 2 | Bit 0: A continuous; bit 1: B enabled |
| resume_sel | input | 1 | 0: A resumes at interrupted channel; 1: A restarts |
| mask_a | input | NCH | Channel mask of sequence A |
| mask_b | input | NCH | Channel mask of sequence B |
| trg_en_a | input | 1 | Trigger enable of A |
| trg_en_b | input | 1 | Trigger enable of B |
| trg_sel_a | input | 2 | Trigger source code of A |
| trg_sel_b | input | 2 | Trigger source code of B |
| sw_trig_a | input | 1 | Dedicated start input of A |
| sw_trig_b | input | 1 | Dedicated start input of B |
| ext_trg_a | input | 2 | External trigger lines 0 and 1 for A |
| ext_trg_b | input | 2 | External trigger lines 0 and 1 for B |
| stop | input | 1 | Abort all scans |
| ie_a | input | 1 | Interrupt enable of A |
| ie_b | input | 1 | Interrupt enable of B |
| eoc_clr_a | input | 1 | Clear eoc_a |
| eoc_clr_b | input | 1 | Clear eoc_b |
| conv_done | input | 1 | Converter finished the current channel |
| conv_start | output | 1 | Start a conversion on conv_ch |
| conv_ch | output | $clog2(NCH) | Channel index to convert |
| busy | output | 1 | A scan of either sequence is in progress |
| eoc_a | output | 1 | Sequence A end-of-scan flag |
| eoc_b | output | 1 | Sequence B end-of-scan flag |
| irq_a | output | 1 | Sequence A interrupt |
| irq_b | output | 1 | Sequence B interrupt |

## Verification
The channel order is checked against masks of several shapes: a sparse A-only mask, masks where B preempts at the first or the second A channel, a single-channel A mask at the top index, and a B trigger fired in a mode that bars B. Comparing resume_sel 0 against 1 on the same masks shows whether the lost channel is reconverted or the whole scan is redone. The single-top-channel case catches a wrong search bound. Continuous mode, sending the same trigger again mid-scan, an empty mask and each trigger-select code are used to tell apart a sequencer that restarts correctly from one that accepts stray triggers.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 17,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     scan_mode,
  input  logic           resume_sel,
  input  logic [NCH-1:0] mask_a,
  input  logic [NCH-1:0] mask_b,
  input  logic           trg_en_a,
  input  logic           trg_en_b,
  input  logic [1:0]     trg_sel_a,
  input  logic [1:0]     trg_sel_b,
  input  logic           sw_trig_a,
  input  logic           sw_trig_b,
  input  logic [1:0]     ext_trg_a,
  input  logic [1:0]     ext_trg_b,
  input  logic           stop,
  input  logic           ie_a,
  input  logic           ie_b,
  input  logic           eoc_clr_a,
  input  logic           eoc_clr_b,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic           busy,
  output logic           eoc_a,
  output logic           eoc_b,
  output logic           irq_a,
  output logic           irq_b
);

  function automatic logic pick(input logic [1:0] sel, input logic sw, input logic [1:0] ext);
    case (sel)
      2'd0:    return sw;
      2'd1:    return ext[0];
      2'd2:    return ext[1];
      default: return |ext;
    endcase
  endfunction

  // {found, index} of the lowest set bit at or above 'from'
  function automatic logic [CHW:0] seek(input logic [NCH-1:0] m, input int from);
    logic [CHW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i] && i >= from) r = {1'b1, CHW'(i)};
    return r;
  endfunction

  logic           a_act, b_act;
  logic [CHW-1:0] pos_a, pos_b;
  logic           n_a_act, n_b_act, n_start, set_a, set_b;
  logic [CHW-1:0] n_pos_a, n_pos_b;
  logic [CHW:0]   nxt_a, nxt_b, fst_a, fst_b;
  logic           go_a, go_b;

  assign go_a  = trg_en_a & pick(trg_sel_a, sw_trig_a, ext_trg_a) & (|mask_a);
  assign go_b  = trg_en_b & pick(trg_sel_b, sw_trig_b, ext_trg_b) & (|mask_b) & scan_mode[1];
  assign nxt_a = seek(mask_a, int'(pos_a) + 1);
  assign nxt_b = seek(mask_b, int'(pos_b) + 1);
  assign fst_a = seek(mask_a, 0);
  assign fst_b = seek(mask_b, 0);

  always_comb begin
    n_a_act = a_act;
    n_b_act = b_act;
    n_pos_a = pos_a;
    n_pos_b = pos_b;
    n_start = 1'b0;
    set_a   = 1'b0;
    set_b   = 1'b0;
    if (stop) begin
      n_a_act = 1'b0;
      n_b_act = 1'b0;
    end else if (b_act) begin
      if (conv_done) begin
        if (nxt_b[CHW]) begin
          n_pos_b = nxt_b[CHW-1:0];
          n_start = 1'b1;
        end else begin
          set_b   = 1'b1;
          n_b_act = 1'b0;
          if (a_act) begin
            if (resume_sel) begin
              n_pos_a = fst_a[CHW-1:0];
              n_a_act = fst_a[CHW];
              n_start = fst_a[CHW];
            end else begin
              n_start = 1'b1;
            end
          end
        end
      end
    end else if (go_b) begin
      n_b_act = 1'b1;
      n_pos_b = fst_b[CHW-1:0];
      n_start = 1'b1;
    end else if (a_act) begin
      if (conv_done) begin
        if (nxt_a[CHW]) begin
          n_pos_a = nxt_a[CHW-1:0];
          n_start = 1'b1;
        end else begin
          set_a = 1'b1;
          if (scan_mode[0]) begin
            n_pos_a = fst_a[CHW-1:0];
            n_a_act = fst_a[CHW];
            n_start = fst_a[CHW];
          end else begin
            n_a_act = 1'b0;
          end
        end
      end
    end else if (go_a) begin
      n_a_act = 1'b1;
      n_pos_a = fst_a[CHW-1:0];
      n_start = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_act      <= 1'b0;
      b_act      <= 1'b0;
      pos_a      <= '0;
      pos_b      <= '0;
      conv_start <= 1'b0;
      eoc_a      <= 1'b0;
      eoc_b      <= 1'b0;
    end else begin
      a_act      <= n_a_act;
      b_act      <= n_b_act;
      pos_a      <= n_pos_a;
      pos_b      <= n_pos_b;
      conv_start <= n_start;
      eoc_a      <= set_a | (eoc_a & ~eoc_clr_a);
      eoc_b      <= set_b | (eoc_b & ~eoc_clr_b);
    end
  end

  assign conv_ch = b_act ? pos_b : pos_a;
  assign busy    = a_act | b_act;
  assign irq_a   = eoc_a & ie_a;
  assign irq_b   = eoc_b & ie_b;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 17,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     scan_mode,
  input logic [NCH-1:0] mask_a,
  input logic [NCH-1:0] mask_b,
  input logic           stop,
  input logic           eoc_clr_a,
  input logic           conv_done,
  input logic           conv_start,
  input logic [CHW-1:0] conv_ch,
  input logic           busy,
  input logic           b_act,
  input logic           eoc_a,
  input logic           eoc_b
);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !conv_start));

  assert_eoc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_a) |-> ($past(conv_done) && !$past(stop)));

  assert_eoc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_a && !eoc_clr_a) |=> eoc_a);

  assert_b_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_b) |-> $past(scan_mode[1]));

  assert_mask_member_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (b_act ? mask_b[conv_ch] : mask_a[conv_ch]));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .mask_a(mask_a), .mask_b(mask_b),
  .stop(stop), .eoc_clr_a(eoc_clr_a), .conv_done(conv_done), .conv_start(conv_start),
  .conv_ch(conv_ch), .busy(busy), .b_act(b_act), .eoc_a(eoc_a), .eoc_b(eoc_b)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int NCH = 17;
  localparam int CHW = $clog2(NCH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] scan_mode = 2'd0;
  logic resume_sel = 1'b0;
  logic [NCH-1:0] mask_a = '0, mask_b = '0;
  logic trg_en_a = 1'b1, trg_en_b = 1'b1;
  logic [1:0] trg_sel_a = 2'd0, trg_sel_b = 2'd0;
  logic sw_trig_a = 1'b0, sw_trig_b = 1'b0;
  logic [1:0] ext_trg_a = 2'd0, ext_trg_b = 2'd0;
  logic stop = 1'b0, ie_a = 1'b0, ie_b = 1'b1, eoc_clr_a = 1'b0, eoc_clr_b = 1'b0;
  logic conv_done;
  logic conv_start, busy, eoc_a, eoc_b, irq_a, irq_b;
  logic [CHW-1:0] conv_ch;

  int tests = 0, fails = 0;
  int log_ch [64];
  int log_n = 0;
  int cnt = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .resume_sel(resume_sel),
    .mask_a(mask_a), .mask_b(mask_b), .trg_en_a(trg_en_a), .trg_en_b(trg_en_b),
    .trg_sel_a(trg_sel_a), .trg_sel_b(trg_sel_b), .sw_trig_a(sw_trig_a), .sw_trig_b(sw_trig_b),
    .ext_trg_a(ext_trg_a), .ext_trg_b(ext_trg_b), .stop(stop), .ie_a(ie_a), .ie_b(ie_b),
    .eoc_clr_a(eoc_clr_a), .eoc_clr_b(eoc_clr_b), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch), .busy(busy), .eoc_a(eoc_a), .eoc_b(eoc_b),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // converter model: done three cycles after start, restarted by every new start
  initial begin
    conv_done = 1'b0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (!rst_n) cnt = 0;
      else if (conv_start) begin
        cnt = 3;
        if (log_n < 64) log_ch[log_n] = int'(conv_ch);
        log_n++;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) conv_done = 1'b1;
      end
    end
  end

  typedef struct packed {
    logic [1:0]      mode;
    logic            res;
    logic [16:0]     ma;
    logic [16:0]     mb;
    logic [3:0]      fire;
    logic [3:0]      n;
    logic [7:0][4:0] ex;
    logic            ea;
    logic            eb;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{2'd0, 1'b0, 17'h00125, 17'h00000, 4'd0, 4'd4,
      {5'd0, 5'd0, 5'd0, 5'd0, 5'd8, 5'd5, 5'd2, 5'd0}, 1'b1, 1'b0},
    '{2'd2, 1'b0, 17'h0001A, 17'h10080, 4'd2, 4'd6,
      {5'd0, 5'd0, 5'd4, 5'd3, 5'd16, 5'd7, 5'd3, 5'd1}, 1'b1, 1'b1},
    '{2'd2, 1'b1, 17'h0001A, 17'h10080, 4'd2, 4'd7,
      {5'd0, 5'd4, 5'd3, 5'd1, 5'd16, 5'd7, 5'd3, 5'd1}, 1'b1, 1'b1},
    '{2'd0, 1'b0, 17'h00003, 17'h00004, 4'd1, 4'd2,
      {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd1, 5'd0}, 1'b1, 1'b0},
    '{2'd2, 1'b0, 17'h10000, 17'h00001, 4'd1, 4'd3,
      {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd16, 5'd0, 5'd16}, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_a();
    sw_trig_a = 1'b1; step(); sw_trig_a = 1'b0;
  endtask

  task automatic clear_flags();
    eoc_clr_a = 1'b1; eoc_clr_b = 1'b1; step(); eoc_clr_a = 1'b0; eoc_clr_b = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) step();
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 400 && log_n < n; i++) step();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    bit fired;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(!busy && !conv_start, "R10 reset idle", int'(busy), 0);
    chk(!eoc_a && !eoc_b && !irq_a && !irq_b, "R6 R7 reset flags", int'({eoc_a, eoc_b, irq_a, irq_b}), 0);

    // table walk: scan order, preemption and resume policy
    for (int v = 0; v < 5; v++) begin
      scan_mode = VT[v].mode; resume_sel = VT[v].res;
      mask_a = VT[v].ma; mask_b = VT[v].mb;
      clear_flags();
      log_n = 0; fired = 1'b0;
      pulse_a();
      for (int i = 0; i < 400; i++) begin
        sw_trig_b = 1'b0;
        if (VT[v].fire != 0 && !fired && log_n == int'(VT[v].fire)) begin
          sw_trig_b = 1'b1; fired = 1'b1;
        end
        if (!busy && !sw_trig_b) break;
        step();
      end
      sw_trig_b = 1'b0;
      chk(log_n == int'(VT[v].n), "R1 R4 R5 conversion count", log_n, int'(VT[v].n));
      for (int k = 0; k < int'(VT[v].n); k++)
        chk(log_ch[k] == int'(VT[v].ex[k]), "R1 R4 R5 channel order", log_ch[k], int'(VT[v].ex[k]));
      chk(eoc_a == VT[v].ea, "R6 eoc_a at scan end", int'(eoc_a), int'(VT[v].ea));
      chk(eoc_b == VT[v].eb, "R3 R6 eoc_b", int'(eoc_b), int'(VT[v].eb));
      chk(irq_b == VT[v].eb, "R7 irq_b with ie_b=1", int'(irq_b), int'(VT[v].eb));
      chk(!irq_a, "R7 irq_a masked", int'(irq_a), 0);
    end

    // trigger source codes and enable
    scan_mode = 2'd0; mask_a = 17'h1; clear_flags();
    trg_sel_a = 2'd1; ext_trg_a = 2'b10; step(); ext_trg_a = 2'b00; step();
    chk(!busy, "R2 code1 ignores line1", int'(busy), 0);
    ext_trg_a = 2'b01; step(); ext_trg_a = 2'b00;
    chk(busy, "R2 code1 takes line0", int'(busy), 1);
    wait_idle();
    trg_sel_a = 2'd2; ext_trg_a = 2'b01; step(); ext_trg_a = 2'b00; step();
    chk(!busy, "R2 code2 ignores line0", int'(busy), 0);
    trg_sel_a = 2'd3; ext_trg_a = 2'b10; step(); ext_trg_a = 2'b00;
    chk(busy, "R2 code3 takes line1", int'(busy), 1);
    wait_idle();
    trg_sel_a = 2'd0; trg_en_a = 1'b0; pulse_a(); step();
    chk(!busy, "R2 enable off", int'(busy), 0);
    trg_en_a = 1'b1;

    // empty mask and retrigger
    mask_a = '0; pulse_a();
    chk(!busy, "R9 empty mask ignored", int'(busy), 0);
    mask_a = 17'h3; log_n = 0; pulse_a();
    wait_log(1); pulse_a(); wait_idle();
    chk(log_n == 2, "R9 retrigger ignored", log_n, 2);

    // eoc clear and irq
    chk(eoc_a, "R6 eoc_a held", int'(eoc_a), 1);
    ie_a = 1'b1; step();
    chk(irq_a, "R7 irq_a enabled", int'(irq_a), 1);
    eoc_clr_a = 1'b1; step(); eoc_clr_a = 1'b0;
    chk(!eoc_a && !irq_a, "R6 R7 clear", int'({eoc_a, irq_a}), 0);
    ie_a = 1'b0;

    // continuous A, then stop
    scan_mode = 2'd1; mask_a = 17'h6; log_n = 0; pulse_a();
    wait_log(5);
    chk(log_ch[0] == 1 && log_ch[1] == 2 && log_ch[2] == 1 && log_ch[3] == 2 && log_ch[4] == 1,
        "R3 continuous wrap", log_ch[2], 1);
    chk(eoc_a, "R3 R6 eoc in continuous", int'(eoc_a), 1);
    stop = 1'b1; step(); stop = 1'b0;
    chk(!busy, "R8 stop idles", int'(busy), 0);
    n0 = log_n; repeat (8) step();
    chk(log_n == n0 && !conv_start, "R8 no start after stop", log_n, n0);

    // stop mid-scan sets no flag
    scan_mode = 2'd0; mask_a = 17'h7; clear_flags(); log_n = 0; pulse_a();
    wait_log(1);
    stop = 1'b1; step(); stop = 1'b0; repeat (8) step();
    chk(!eoc_a && log_n == 1, "R8 abort without eoc", int'(eoc_a), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule